// File: doc/BRIEF.md
# MMU Control Registers with Translation Cache

This block pairs the configuration registers of an address-translation unit with a small fully associative translation cache. Software programs the registers over a 32-bit register bus: a control word holding the cache enable and a one-shot invalidate request, a secondary control word, an address-space identifier, the first-level table base and a code that selects the first-level table length. The base, size code and identifier are driven out to the table walker, which lies outside this block.

Clients present a virtual address on the lookup port. The block answers in the same cycle with a hit and the translated physical address, or with a fill request carrying that address. The walker answers a fill request with a page number pair and a page size, and the block allocates an entry for it. Three page sizes are cached: 4 KiB, 64 KiB and 1 MiB. Each entry compares only the address bits above its own page size.

Top module: `mmu_tlb_ctrl`

## Requirements
- R1: After reset every register reads as zero, the cache is disabled and lookups neither hit nor request a fill.
- R2: A write to offset 0x000 sets the enable state to bit 0 of the written value, whether or not bit 1 is set in the same write. The register reads back the enable in bit 0 and always reads bit 1 as zero. Enabling without an invalidate keeps the entries already cached.
- R3: Writing 1 to bit 1 of offset 0x000 invalidates every entry on the clock edge after the edge that takes the write. A lookup in the cycle between those two edges still hits.
- R4: While the cache is disabled, lookups report a miss with no fill request, and fills are dropped: no entry is allocated.
- R5: While the cache is enabled, a lookup that matches no entry raises fill_req_o for that cycle, with fill_va_o equal to the lookup address.
- R6: A 4 KiB entry (page code 0) hits only on an exact match of address bits 31:12. It returns its physical page with address bits 11:0 passed through.
- R7: A 64 KiB entry (page code 1) ignores bits 15:12 of both the fill page numbers and the lookup address. It hits anywhere in its 64 KiB region and passes lookup bits 15:0 through.
- R8: A 1 MiB entry (page code 2) ignores bits 19:12 of both the fill page numbers and the lookup address. It hits anywhere in its 1 MiB region and passes lookup bits 19:0 through.
- R9: A fill goes to the lowest-numbered invalid entry. When every entry is valid, fills replace entries in round-robin order starting at entry 0. An invalidate resets this order.
- R10: Offset 0x018 holds a 3-bit table-size code. Codes 1 through 7 mean first-level tables of 8 KiB down to 128 B, halving with each step. The code is read back and driven on tbl_size_o.
- R11: A write to the base register at offset 0x014 clears the bits below the alignment of the current size code: bits 13-c..0 for code c from 1 to 7. Code 0 keeps every bit.
- R12: Offset 0x004 is a 32-bit secondary control word that reads back as written and drives aux_ctrl_o, where zero means the secondary unit is off. Unmapped offsets read zero.
- R13: Offset 0x010 holds an ASID_W-bit address-space identifier. Higher written bits are dropped, and the value is read back and driven on asid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pa_o | output | 32 | Translated physical address, zero on miss |
| fill_req_o | output | 1 | Miss, fill requested from walker |
| fill_va_o | output | 32 | Virtual address to walk |
| fill_valid_i | input | 1 | Walker delivers a translation |
| fill_vpn_i | input | 20 | Virtual page number of the fill |
| fill_ppn_i | input | 20 | Physical page number of the fill |
| fill_pg_i | input | 2 | Page code: 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB |
| tbl_base_o | output | 32 | First-level table base to walker |
| tbl_size_o | output | 3 | Table-size code to walker |
| asid_o | output | ASID_W | Address-space identifier to walker |
| aux_ctrl_o | output | 32 | Secondary control word |

## Verification
Round-robin replacement is the hardest state to reach from the ports. Every entry must be valid first, and the pointer is not visible from outside. The bench fills all four entries with mixed page sizes and then issues two more fills. Lookups of the first two regions now miss while the other two still hit, which shows the victim order. The one-cycle gap before an invalidate takes effect is also caught. A lookup is held steady across the invalidate write and sampled both in the cycle between the two edges and in the cycle after.

// File: rtl/mmu_tlb_pkg.sv
package mmu_tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 12;
  localparam int VPN_W    = VA_W - PG_SHIFT;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_AUX  = 8'h04;
  localparam logic [7:0] OFF_ASID = 8'h10;
  localparam logic [7:0] OFF_BASE = 8'h14;
  localparam logic [7:0] OFF_SIZE = 8'h18;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_RSV = 2'd3
  } pg_e;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] tag;
    pg_e              pg;
    logic [VPN_W-1:0] ppn;
  } tlb_ent_t;

  // page-number bits that take part in tag compare
  function automatic logic [VPN_W-1:0] pg_mask(pg_e pg);
    case (pg)
      PG_64K:  pg_mask = {{(VPN_W-4){1'b1}}, 4'h0};
      PG_1M:   pg_mask = {{(VPN_W-8){1'b1}}, 8'h00};
      default: pg_mask = '1;
    endcase
  endfunction

  // base bits kept for a given table-size code
  function automatic logic [31:0] base_keep(logic [2:0] code);
    int sh;
    sh = 14 - int'(code);
    if (code == 3'd0) base_keep = '1;
    else              base_keep = ~((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/mmu_regs.sv
module mmu_regs
  import mmu_tlb_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              en_o,
  output logic              flush_o,
  output logic [31:0]       aux_o,
  output logic [ASID_W-1:0] asid_o,
  output logic [31:0]       base_o,
  output logic [2:0]        size_o
);
  logic              en_q, flush_q;
  logic [31:0]       aux_q, base_q;
  logic [ASID_W-1:0] asid_q;
  logic [2:0]        size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
      aux_q   <= '0;
      base_q  <= '0;
      asid_q  <= '0;
      size_q  <= '0;
    end else begin
      flush_q <= wr_i && (addr_i == REG_AW'(OFF_CTRL)) && wdata_i[1];
      if (wr_i) begin
        case (addr_i)
          REG_AW'(OFF_CTRL): en_q   <= wdata_i[0];
          REG_AW'(OFF_AUX):  aux_q  <= wdata_i;
          REG_AW'(OFF_ASID): asid_q <= wdata_i[ASID_W-1:0];
          REG_AW'(OFF_BASE): base_q <= wdata_i & base_keep(size_q);
          REG_AW'(OFF_SIZE): size_q <= wdata_i[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      REG_AW'(OFF_CTRL): rdata_o = {31'd0, en_q};
      REG_AW'(OFF_AUX):  rdata_o = aux_q;
      REG_AW'(OFF_ASID): rdata_o = 32'(asid_q);
      REG_AW'(OFF_BASE): rdata_o = base_q;
      REG_AW'(OFF_SIZE): rdata_o = 32'(size_q);
      default:           rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign flush_o = flush_q;
  assign aux_o   = aux_q;
  assign asid_o  = asid_q;
  assign base_o  = base_q;
  assign size_o  = size_q;
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import mmu_tlb_pkg::*;
(
  input  logic             valid_i,
  input  logic [VPN_W-1:0] tag_i,
  input  pg_e              pg_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic             hit_o
);
  assign hit_o = valid_i && ((vpn_i & pg_mask(pg_i)) == tag_i);
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import mmu_tlb_pkg::*;
#(
  parameter int N_ENT = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  flush_i,
  input  logic                  fill_i,
  input  logic [VPN_W-1:0]      fill_vpn_i,
  input  logic [VPN_W-1:0]      fill_ppn_i,
  input  pg_e                   fill_pg_i,
  output tlb_ent_t [N_ENT-1:0]  ents_o
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  tlb_ent_t [N_ENT-1:0] ents_q;
  logic [IDX_W-1:0]     rr_q, free_idx, victim;
  logic                 free_found;
  logic [VPN_W-1:0]     m;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!ents_q[i].valid) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    victim = free_found ? free_idx : rr_q;
    m      = pg_mask(fill_pg_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ents_q <= '0;
      rr_q   <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < N_ENT; i++) ents_q[i].valid <= 1'b0;
      rr_q <= '0;
    end else if (fill_i && en_i) begin
      ents_q[victim] <= '{valid: 1'b1, tag: fill_vpn_i & m,
                          pg: fill_pg_i, ppn: fill_ppn_i & m};
      if (!free_found) begin
        if (rr_q == IDX_W'(N_ENT - 1)) rr_q <= '0;
        else                           rr_q <= rr_q + 1'b1;
      end
    end
  end

  assign ents_o = ents_q;
endmodule

// File: rtl/mmu_tlb_ctrl.sv
module mmu_tlb_ctrl
  import mmu_tlb_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int ASID_W = 8,
  parameter int N_ENT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              lk_req_i,
  input  logic [31:0]       lk_va_i,
  output logic              lk_hit_o,
  output logic [31:0]       lk_pa_o,
  output logic              fill_req_o,
  output logic [31:0]       fill_va_o,
  input  logic              fill_valid_i,
  input  logic [19:0]       fill_vpn_i,
  input  logic [19:0]       fill_ppn_i,
  input  logic [1:0]        fill_pg_i,
  output logic [31:0]       tbl_base_o,
  output logic [2:0]        tbl_size_o,
  output logic [ASID_W-1:0] asid_o,
  output logic [31:0]       aux_ctrl_o
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic                 tlb_en, tlb_flush;
  tlb_ent_t [N_ENT-1:0] ents;
  logic [N_ENT-1:0]     match;
  logic [IDX_W-1:0]     sel;
  logic [VPN_W-1:0]     lk_vpn, sel_mask, out_ppn;
  logic                 any_match;

  mmu_regs #(.REG_AW(REG_AW), .ASID_W(ASID_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_o    (tlb_en),
    .flush_o (tlb_flush),
    .aux_o   (aux_ctrl_o),
    .asid_o  (asid_o),
    .base_o  (tbl_base_o),
    .size_o  (tbl_size_o)
  );

  tlb_store #(.N_ENT(N_ENT)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tlb_en),
    .flush_i    (tlb_flush),
    .fill_i     (fill_valid_i),
    .fill_vpn_i (fill_vpn_i),
    .fill_ppn_i (fill_ppn_i),
    .fill_pg_i  (pg_e'(fill_pg_i)),
    .ents_o     (ents)
  );

  assign lk_vpn = lk_va_i[31:PG_SHIFT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_match
    tlb_match i_match (
      .valid_i (ents[g].valid),
      .tag_i   (ents[g].tag),
      .pg_i    (ents[g].pg),
      .vpn_i   (lk_vpn),
      .hit_o   (match[g])
    );
  end

  // lowest index wins on duplicate matches
  always_comb begin
    sel = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) sel = IDX_W'(i);
    end
    any_match = |match;
    sel_mask  = pg_mask(ents[sel].pg);
    out_ppn   = ents[sel].ppn | (lk_vpn & ~sel_mask);
  end

  assign lk_hit_o   = lk_req_i && tlb_en && any_match;
  assign lk_pa_o    = lk_hit_o ? {out_ppn, lk_va_i[PG_SHIFT-1:0]} : '0;
  assign fill_req_o = lk_req_i && tlb_en && !any_match;
  assign fill_va_o  = lk_va_i;
endmodule

// File: rtl/mmu_tlb_chk.sv
module mmu_tlb_chk
  import mmu_tlb_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic              lk_req_i,
  input logic              lk_hit_o,
  input logic              fill_req_o,
  input logic [31:0]       tbl_base_o,
  input logic [2:0]        tbl_size_o,
  input logic              tlb_en
);
  // R4: no hit while the cache is off
  a_r4_no_hit_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tlb_en |-> !lk_hit_o);

  // R5: an enabled lookup either hits or asks for a fill, never both
  a_r5_hit_or_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && tlb_en) |-> (lk_hit_o != fill_req_o));

  // R2: invalidate bit never reads back set
  a_r2_flush_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == REG_AW'(OFF_CTRL)) |-> !reg_rdata_o[1]);

  // R3: no hit two cycles after an invalidate write
  a_r3_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == REG_AW'(OFF_CTRL) && reg_wdata_i[1]) |=> ##1 !lk_hit_o);

  // R11: freshly written base respects the size-code alignment
  a_r11_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == REG_AW'(OFF_BASE)) |=>
      ((tbl_base_o & ~base_keep(tbl_size_o)) == 32'd0));
endmodule

bind mmu_tlb_ctrl mmu_tlb_chk #(.REG_AW(REG_AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .lk_req_i    (lk_req_i),
  .lk_hit_o    (lk_hit_o),
  .fill_req_o  (fill_req_o),
  .tbl_base_o  (tbl_base_o),
  .tbl_size_o  (tbl_size_o),
  .tlb_en      (tlb_en)
);

// File: tb/test_mmu_tlb_ctrl.sv
module test_mmu_tlb_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        lk_req_i = 1'b0;
  logic [31:0] lk_va_i = '0;
  logic        lk_hit_o;
  logic [31:0] lk_pa_o;
  logic        fill_req_o;
  logic [31:0] fill_va_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [19:0] fill_ppn_i = '0;
  logic [1:0]  fill_pg_i = '0;
  logic [31:0] tbl_base_o;
  logic [2:0]  tbl_size_o;
  logic [7:0]  asid_o;
  logic [31:0] aux_ctrl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mmu_tlb_ctrl i_mmu_tlb_ctrl (.*);

  // {va, expected hit, expected pa} after the first four fills
  localparam logic [64:0] VEC [8] = '{
    {32'h0001_2ABC, 1'b1, 32'h8000_0ABC},
    {32'h0001_3000, 1'b0, 32'h0000_0000},
    {32'h0023_F123, 1'b1, 32'h9001_F123},
    {32'h0024_0000, 1'b0, 32'h0000_0000},
    {32'h0022_FFFF, 1'b0, 32'h0000_0000},
    {32'h040F_FFFC, 1'b1, 32'hA01F_FFFC},
    {32'h0410_0000, 1'b0, 32'h0000_0000},
    {32'h0005_5FFF, 1'b1, 32'hB000_3FFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [1:0] pg);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn; fill_pg_i = pg;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va);
    @(negedge clk_i);
    lk_req_i = 1'b1; lk_va_i = va;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: reset state
    reg_read(8'h00, rd); check("R1 ctrl", rd, 0);
    reg_read(8'h04, rd); check("R1 aux", rd, 0);
    reg_read(8'h10, rd); check("R1 asid", rd, 0);
    reg_read(8'h14, rd); check("R1 base", rd, 0);
    reg_read(8'h18, rd); check("R1 size", rd, 0);
    lookup(32'h0001_2ABC);
    check("R1 hit", 32'(lk_hit_o), 0);
    check("R4 fill_req off", 32'(fill_req_o), 0);

    // R4: fill while disabled is dropped
    fill(20'h00012, 20'h80000, 2'd0);
    reg_write(8'h00, 32'h1);
    lookup(32'h0001_2ABC);
    check("R4 no alloc", 32'(lk_hit_o), 0);
    check("R5 fill_req", 32'(fill_req_o), 1);
    check("R5 fill_va", fill_va_o, 32'h0001_2ABC);

    // R10 R11 R12 R13: register file
    reg_write(8'h18, 32'hFFFF_FFFB);
    reg_read(8'h18, rd); check("R10 size", rd, 3);
    check("R10 size port", 32'(tbl_size_o), 3);
    reg_write(8'h14, 32'hFFFF_FFFF);
    reg_read(8'h14, rd); check("R11 code3", rd, 32'hFFFF_F800);
    reg_write(8'h18, 32'h7);
    reg_write(8'h14, 32'hFFFF_FFFF);
    check("R11 code7", tbl_base_o, 32'hFFFF_FF80);
    reg_write(8'h18, 32'h1);
    reg_write(8'h14, 32'h1234_5678);
    check("R11 code1", tbl_base_o, 32'h1234_4000);
    reg_write(8'h18, 32'h0);
    reg_write(8'h14, 32'h1234_5678);
    check("R11 code0", tbl_base_o, 32'h1234_5678);
    reg_write(8'h10, 32'h0000_01FF);
    reg_read(8'h10, rd); check("R13 asid", rd, 32'hFF);
    check("R13 asid port", 32'(asid_o), 32'hFF);
    reg_write(8'h04, 32'hA5A5_0001);
    reg_read(8'h04, rd); check("R12 aux", rd, 32'hA5A5_0001);
    reg_write(8'h04, 32'h0);
    check("R12 aux off", aux_ctrl_o, 0);
    reg_read(8'h0C, rd); check("R12 unmapped", rd, 0);

    // R6 R7 R8: mixed page sizes, unaligned bits masked
    fill(20'h00012, 20'h80000, 2'd0);
    fill(20'h00238, 20'h90015, 2'd1);
    fill(20'h040AB, 20'hA01CD, 2'd2);
    fill(20'h00055, 20'hB0003, 2'd0);
    foreach (VEC[i]) begin
      lookup(VEC[i][64:33]);
      check($sformatf("R6/R7/R8 hit vec%0d", i), 32'(lk_hit_o), 32'(VEC[i][32]));
      check($sformatf("R6/R7/R8 pa vec%0d", i), lk_pa_o, VEC[i][31:0]);
    end

    // R9: round-robin replacement once full
    fill(20'h00700, 20'hC0000, 2'd0);
    lookup(32'h0001_2000); check("R9 e0 replaced", 32'(lk_hit_o), 0);
    lookup(32'h0070_0010); check("R9 new pa", lk_pa_o, 32'hC000_0010);
    fill(20'h00710, 20'hC1000, 2'd0);
    lookup(32'h0023_F123); check("R9 e1 replaced", 32'(lk_hit_o), 0);
    lookup(32'h0400_0000); check("R9 e2 kept", 32'(lk_hit_o), 1);

    // R3: invalidate with enable, one-cycle latency
    lk_req_i = 1'b1; lk_va_i = 32'h0400_0000;
    reg_write(8'h00, 32'h3);
    #1 check("R3 still valid", 32'(lk_hit_o), 1);
    @(negedge clk_i);
    #1 check("R3 cleared", 32'(lk_hit_o), 0);
    reg_read(8'h00, rd); check("R2 ctrl readback", rd, 1);

    // R2: invalidate without enable clears enable
    reg_write(8'h00, 32'h2);
    reg_read(8'h00, rd); check("R2 disabled", rd, 0);

    // R9 R2 R4: free entry first, disable keeps entries, fills dropped
    reg_write(8'h00, 32'h1);
    fill(20'h00900, 20'hD0000, 2'd0);
    lookup(32'h0090_0004); check("R9 free entry", lk_pa_o, 32'hD000_0004);
    reg_write(8'h00, 32'h0);
    lookup(32'h0090_0004);
    check("R4 miss off", 32'(lk_hit_o), 0);
    check("R4 no fill_req", 32'(fill_req_o), 0);
    fill(20'h00910, 20'hD1000, 2'd0);
    reg_write(8'h00, 32'h1);
    lookup(32'h0091_0000); check("R4 dropped fill", 32'(lk_hit_o), 0);
    lookup(32'h0090_0004); check("R2 entries kept", 32'(lk_hit_o), 1);

    lk_req_i = 1'b0;
    finish_run();
  end
endmodule